// File: doc/BRIEF.md
# Wear-Aware Flash Block Victim Selector

This block decides which flash block gives up its pages when either the read-cache region or the write-cache region of a flash disk cache runs short of free space. It keeps a small record for every block: how many erases it has seen, the summed error-correction strength of its pages, how many of its pages were forced from multi-level to single-level storage, a recency stamp and the region it belongs to. From the first three it forms a weighted wear score. The score is the erase count, plus weight A times the ECC total, plus weight B times the single-level page count. B is meant to exceed A, because a density downgrade signals more wear than a stronger code does.

On a request, the selector walks all blocks one per cycle. It finds the least recently used live block of the requesting region and the least worn live block anywhere in the device. The recency candidate is the default victim. If the candidate's score exceeds the device-wide minimum by more than a programmable threshold, the least-worn block is chosen instead. In that case a migrate flag tells the caller to move the young block's data into the worn block before erasing. Software-side tables feed the per-block record through a single update port. The data movement and the erase itself happen elsewhere.

Top module: `wear_victim_sel`

## Requirements
- R1: The wear score of a block equals erase count + cfg_k1 × ECC total + cfg_k2 × single-level page count, clamped at the largest SCORE_W-bit value. The caller keeps cfg_k2 > cfg_k1.
- R2: The update op codes on upd_op act on block upd_blk when upd_valid is high. Code 1 (erase) adds one to the erase count, which stops at 2^ERASE_W−1. Code 2 adds upd_val to the ECC total, which stops at PAGES_MLC × MAX_ECC (1536 by default). Code 3 adds one to the single-level page count, which stops at PAGES_MLC.
- R3: Op code 4 (touch) makes a block the most recently used. The recency candidate is the live block of the requesting region with the oldest touch, with ties going to the lowest index. req_region uses 0 for read and 1 for write.
- R4: After reset, blocks with index below NUM_BLK × READ_PCT / 100 (14 of 16 by default) belong to the read region and the rest to the write region. Op code 5 moves a block to the read region and op code 6 moves it to the write region.
- R5: The minimum-wear block is the live block of either region with the lowest score, with ties going to the lowest index.
- R6: Let D be the candidate's score minus the minimum score. If D exceeds the threshold sampled with the request, the victim is the minimum-wear block and migrate is 1. Otherwise the victim is the candidate and migrate is 0.
- R7: Op code 7 retires a block, and retired blocks take part in neither search. If the requesting region has no live block, found is 0 and migrate is 0.
- R8: A request is taken only while busy is low, and busy is high from the next cycle. done is a one-cycle pulse NUM_BLK+1 cycles after the accepting edge, with found, victim and migrate valid from then on. A request raised while busy is dropped.
- R9: Reset clears busy, done, all counts, all recency stamps and all retire marks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_k1 | input | WT_W | Weight on the ECC total |
| cfg_k2 | input | WT_W | Weight on the single-level page count |
| cfg_thresh | input | SCORE_W | Allowed score gap before the override, sampled with the request |
| upd_valid | input | 1 | Apply upd_op this cycle |
| upd_op | input | 3 | Update op code (see R2, R3, R4, R7) |
| upd_blk | input | BLK_W | Block the update targets |
| upd_val | input | ECC_W | Amount added by op code 2 |
| req | input | 1 | Start a victim search |
| req_region | input | 1 | Requesting region, 0 read, 1 write |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| found | output | 1 | The region had a live block |
| victim | output | BLK_W | Chosen block index |
| migrate | output | 1 | The minimum-wear block was chosen instead of the candidate |

## Verification
On every cycle, the embedded properties check the following. done never lasts two cycles. An accepted request raises busy. migrate never appears without found. A migrating result never names the recency candidate. An erase adds exactly one to the count unless the count has saturated. The ECC total never passes its cap.

Only the bench's scenarios can show that the recency order, the region split, the retire exclusion and the lowest-index tie rules pick the right block. The same holds for the strict comparison at a gap equal to the threshold and for the use of the weights in the score. The bench also shows that a request raised during a search leaves no trace.

// File: rtl/wvs_pkg.sv
// Shared types of the wear-aware victim selector.
// Assumes: op codes are fixed by the update interface contract.
package wvs_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ERASE    = 3'd1,
        OP_ECC_ADD  = 3'd2,
        OP_SLC_ADD  = 3'd3,
        OP_TOUCH    = 3'd4,
        OP_TO_READ  = 3'd5,
        OP_TO_WRITE = 3'd6,
        OP_RETIRE   = 3'd7
    } blk_op_e;

    localparam logic REGION_READ  = 1'b0;
    localparam logic REGION_WRITE = 1'b1;

endpackage

// File: rtl/blk_state_bank.sv
// Per-block wear and recency record with one update port and one read port.
// Does: erase/ECC/single-level counters with saturation, recency stamps,
//       region tag and retire mark; exposes the record at rd_idx.
// Assumes: NUM_BLK is a power of two; the recency stamp saturates and is
//       wide enough for the number of touches between resets.
module blk_state_bank
    import wvs_pkg::*;
#(
    parameter int NUM_BLK   = 16,
    parameter int ERASE_W   = 20,
    parameter int PAGES_MLC = 128,
    parameter int MAX_ECC   = 12,
    parameter int READ_PCT  = 90,
    parameter int STAMP_W   = 16,
    localparam int BLK_W     = $clog2(NUM_BLK),
    localparam int ECC_CAP   = PAGES_MLC * MAX_ECC,
    localparam int ECC_W     = $clog2(ECC_CAP + 1),
    localparam int SLC_W     = $clog2(PAGES_MLC + 1),
    localparam int READ_BLKS = NUM_BLK * READ_PCT / 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_valid,
    input  logic [2:0]         upd_op,
    input  logic [BLK_W-1:0]   upd_blk,
    input  logic [ECC_W-1:0]   upd_val,
    input  logic [BLK_W-1:0]   rd_idx,
    output logic [ERASE_W-1:0] rd_erase,
    output logic [ECC_W-1:0]   rd_ecc,
    output logic [SLC_W-1:0]   rd_slc,
    output logic [STAMP_W-1:0] rd_stamp,
    output logic               rd_region,
    output logic               rd_retired
);

    localparam logic [ECC_W-1:0] ECC_CAP_V = ECC_W'(ECC_CAP);
    localparam logic [SLC_W-1:0] SLC_CAP_V = SLC_W'(PAGES_MLC);

    blk_op_e op_e;
    assign op_e = blk_op_e'(upd_op);

    logic [STAMP_W-1:0] stamp_q;
    logic [STAMP_W-1:0] stamp_nxt;
    logic               touch_any;

    assign touch_any = upd_valid && (op_e == OP_TOUCH);
    assign stamp_nxt = (stamp_q == '1) ? stamp_q : stamp_q + 1'b1;

    // Global recency clock: advances once per touch, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)         stamp_q <= '0;
        else if (touch_any) stamp_q <= stamp_nxt;
    end

    logic [ERASE_W-1:0] erase_a   [NUM_BLK];
    logic [ECC_W-1:0]   ecc_a     [NUM_BLK];
    logic [SLC_W-1:0]   slc_a     [NUM_BLK];
    logic [STAMP_W-1:0] stamp_a   [NUM_BLK];
    logic               region_a  [NUM_BLK];
    logic               retired_a [NUM_BLK];

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
        logic [ERASE_W-1:0] erase_q;
        logic [ECC_W-1:0]   ecc_q;
        logic [SLC_W-1:0]   slc_q;
        logic [STAMP_W-1:0] bstamp_q;
        logic               region_q;
        logic               retired_q;
        logic               hit;
        logic [ECC_W:0]     ecc_sum;

        assign hit     = upd_valid && (upd_blk == BLK_W'(g));
        assign ecc_sum = {1'b0, ecc_q} + {1'b0, upd_val};

        // Record update for this block: one op per cycle, all counters saturate.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                erase_q   <= '0;
                ecc_q     <= '0;
                slc_q     <= '0;
                bstamp_q  <= '0;
                region_q  <= (g >= READ_BLKS) ? REGION_WRITE : REGION_READ;
                retired_q <= 1'b0;
            end else if (hit) begin
                unique case (op_e)
                    OP_ERASE:    if (erase_q != '1) erase_q <= erase_q + 1'b1;
                    OP_ECC_ADD:  ecc_q <= (ecc_sum > {1'b0, ECC_CAP_V}) ? ECC_CAP_V
                                                                       : ecc_sum[ECC_W-1:0];
                    OP_SLC_ADD:  if (slc_q != SLC_CAP_V) slc_q <= slc_q + 1'b1;
                    OP_TOUCH:    bstamp_q <= stamp_nxt;
                    OP_TO_READ:  region_q <= REGION_READ;
                    OP_TO_WRITE: region_q <= REGION_WRITE;
                    OP_RETIRE:   retired_q <= 1'b1;
                    default: ;
                endcase
            end
        end

        assign erase_a[g]   = erase_q;
        assign ecc_a[g]     = ecc_q;
        assign slc_a[g]     = slc_q;
        assign stamp_a[g]   = bstamp_q;
        assign region_a[g]  = region_q;
        assign retired_a[g] = retired_q;

        // R2
        erase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && op_e == OP_ERASE && erase_q != '1) |=> erase_q == $past(erase_q) + 1'b1);

        // R2
        ecc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ecc_q <= ECC_CAP_V);
    end

    // Read port used by the sequential search.
    always_comb begin
        rd_erase   = erase_a[rd_idx];
        rd_ecc     = ecc_a[rd_idx];
        rd_slc     = slc_a[rd_idx];
        rd_stamp   = stamp_a[rd_idx];
        rd_region  = region_a[rd_idx];
        rd_retired = retired_a[rd_idx];
    end

endmodule

// File: rtl/wear_score.sv
// Weighted wear score: erase + k1*ecc + k2*slc, clamped to SCORE_W bits.
// Assumes: the internal sum width holds the unclamped result exactly.
module wear_score #(
    parameter int ERASE_W = 20,
    parameter int ECC_W   = 11,
    parameter int SLC_W   = 8,
    parameter int WT_W    = 8,
    parameter int SCORE_W = 24,
    localparam int SUM_W  = ERASE_W + ECC_W + SLC_W + 2 * WT_W
) (
    input  logic [ERASE_W-1:0] erase_cnt,
    input  logic [ECC_W-1:0]   ecc_total,
    input  logic [SLC_W-1:0]   slc_cnt,
    input  logic [WT_W-1:0]    k1,
    input  logic [WT_W-1:0]    k2,
    output logic [SCORE_W-1:0] score
);

    localparam logic [SUM_W-1:0] SCORE_MAX = SUM_W'({SCORE_W{1'b1}});

    logic [SUM_W-1:0] total;

    // Exact weighted sum, then clamp to the score width.
    always_comb begin
        total = SUM_W'(erase_cnt)
              + SUM_W'(k1) * SUM_W'(ecc_total)
              + SUM_W'(k2) * SUM_W'(slc_cnt);
        score = (total > SCORE_MAX) ? '1 : total[SCORE_W-1:0];
    end

endmodule

// File: rtl/victim_scan.sv
// Sequential victim search, one block per cycle.
// Does: tracks the oldest live block of the requesting region and the
//       least-worn live block overall, then applies the threshold override.
// Assumes: the block record is stable while busy; scores of rd_idx arrive
//       combinationally in the same cycle.
module victim_scan #(
    parameter int NUM_BLK = 16,
    parameter int STAMP_W = 16,
    parameter int SCORE_W = 24,
    localparam int BLK_W  = $clog2(NUM_BLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               req_region,
    input  logic [SCORE_W-1:0] thresh,
    output logic [BLK_W-1:0]   rd_idx,
    input  logic [SCORE_W-1:0] cur_score,
    input  logic [STAMP_W-1:0] cur_stamp,
    input  logic               cur_region,
    input  logic               cur_retired,
    output logic               busy,
    output logic               done,
    output logic               found,
    output logic [BLK_W-1:0]   victim,
    output logic               migrate
);

    localparam logic [BLK_W-1:0] LAST_IDX = BLK_W'(NUM_BLK - 1);

    logic               busy_q, done_q, found_q, mig_q;
    logic [BLK_W-1:0]   idx_q, vic_q;
    logic               region_q;
    logic [SCORE_W-1:0] thr_q;
    logic               cand_ok_q, min_ok_q;
    logic [BLK_W-1:0]   cand_blk_q, min_blk_q;
    logic [STAMP_W-1:0] cand_stamp_q;
    logic [SCORE_W-1:0] cand_score_q, min_score_q;

    logic               take_c, take_m, over;
    logic               cand_ok_n, min_ok_n;
    logic [BLK_W-1:0]   cand_blk_n, min_blk_n;
    logic [STAMP_W-1:0] cand_stamp_n;
    logic [SCORE_W-1:0] cand_score_n, min_score_n;

    // Fold the current block into both running searches.
    always_comb begin
        take_c = !cur_retired && (cur_region == region_q)
                 && (!cand_ok_q || cur_stamp < cand_stamp_q);
        take_m = !cur_retired && (!min_ok_q || cur_score < min_score_q);
        cand_ok_n    = cand_ok_q || take_c;
        cand_blk_n   = take_c ? idx_q     : cand_blk_q;
        cand_stamp_n = take_c ? cur_stamp : cand_stamp_q;
        cand_score_n = take_c ? cur_score : cand_score_q;
        min_ok_n     = min_ok_q || take_m;
        min_blk_n    = take_m ? idx_q     : min_blk_q;
        min_score_n  = take_m ? cur_score : min_score_q;
        over = cand_ok_n && min_ok_n && ((cand_score_n - min_score_n) > thr_q);
    end

    // Search sequencer: accept when idle, step the index, publish on the last block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0; done_q <= 1'b0; found_q <= 1'b0; mig_q <= 1'b0;
            idx_q <= '0; vic_q <= '0; region_q <= 1'b0; thr_q <= '0;
            cand_ok_q <= 1'b0; min_ok_q <= 1'b0;
            cand_blk_q <= '0; min_blk_q <= '0; cand_stamp_q <= '0;
            cand_score_q <= '0; min_score_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (req) begin
                    busy_q    <= 1'b1;
                    idx_q     <= '0;
                    region_q  <= req_region;
                    thr_q     <= thresh;
                    cand_ok_q <= 1'b0;
                    min_ok_q  <= 1'b0;
                end
            end else begin
                cand_ok_q    <= cand_ok_n;
                cand_blk_q   <= cand_blk_n;
                cand_stamp_q <= cand_stamp_n;
                cand_score_q <= cand_score_n;
                min_ok_q     <= min_ok_n;
                min_blk_q    <= min_blk_n;
                min_score_q  <= min_score_n;
                idx_q        <= idx_q + 1'b1;
                if (idx_q == LAST_IDX) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    found_q <= cand_ok_n;
                    mig_q   <= over;
                    vic_q   <= over ? min_blk_n : cand_blk_n;
                end
            end
        end
    end

    assign rd_idx  = idx_q;
    assign busy    = busy_q;
    assign done    = done_q;
    assign found   = found_q;
    assign victim  = vic_q;
    assign migrate = mig_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);

    // R7
    mig_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        migrate |-> found);

    // R6
    mig_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && migrate) |-> (victim != cand_blk_q));

endmodule

// File: rtl/wear_victim_sel.sv
// Top of the wear-aware victim selector.
// Does: ties the block record, the score datapath and the search together.
// Assumes: cfg_k2 > cfg_k1 whenever a request is made; updates are not
//       issued while busy.
module wear_victim_sel #(
    parameter int NUM_BLK   = 16,
    parameter int ERASE_W   = 20,
    parameter int PAGES_MLC = 128,
    parameter int MAX_ECC   = 12,
    parameter int READ_PCT  = 90,
    parameter int STAMP_W   = 16,
    parameter int WT_W      = 8,
    parameter int SCORE_W   = 24,
    localparam int BLK_W    = $clog2(NUM_BLK),
    localparam int ECC_W    = $clog2(PAGES_MLC * MAX_ECC + 1),
    localparam int SLC_W    = $clog2(PAGES_MLC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WT_W-1:0]    cfg_k1,
    input  logic [WT_W-1:0]    cfg_k2,
    input  logic [SCORE_W-1:0] cfg_thresh,
    input  logic               upd_valid,
    input  logic [2:0]         upd_op,
    input  logic [BLK_W-1:0]   upd_blk,
    input  logic [ECC_W-1:0]   upd_val,
    input  logic               req,
    input  logic               req_region,
    output logic               busy,
    output logic               done,
    output logic               found,
    output logic [BLK_W-1:0]   victim,
    output logic               migrate
);

    logic [BLK_W-1:0]   rd_idx;
    logic [ERASE_W-1:0] rd_erase;
    logic [ECC_W-1:0]   rd_ecc;
    logic [SLC_W-1:0]   rd_slc;
    logic [STAMP_W-1:0] rd_stamp;
    logic               rd_region, rd_retired;
    logic [SCORE_W-1:0] rd_score;

    blk_state_bank #(
        .NUM_BLK(NUM_BLK), .ERASE_W(ERASE_W), .PAGES_MLC(PAGES_MLC),
        .MAX_ECC(MAX_ECC), .READ_PCT(READ_PCT), .STAMP_W(STAMP_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_op(upd_op), .upd_blk(upd_blk), .upd_val(upd_val),
        .rd_idx(rd_idx), .rd_erase(rd_erase), .rd_ecc(rd_ecc), .rd_slc(rd_slc),
        .rd_stamp(rd_stamp), .rd_region(rd_region), .rd_retired(rd_retired)
    );

    wear_score #(
        .ERASE_W(ERASE_W), .ECC_W(ECC_W), .SLC_W(SLC_W),
        .WT_W(WT_W), .SCORE_W(SCORE_W)
    ) u_score (
        .erase_cnt(rd_erase), .ecc_total(rd_ecc), .slc_cnt(rd_slc),
        .k1(cfg_k1), .k2(cfg_k2), .score(rd_score)
    );

    victim_scan #(
        .NUM_BLK(NUM_BLK), .STAMP_W(STAMP_W), .SCORE_W(SCORE_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n),
        .req(req), .req_region(req_region), .thresh(cfg_thresh),
        .rd_idx(rd_idx), .cur_score(rd_score), .cur_stamp(rd_stamp),
        .cur_region(rd_region), .cur_retired(rd_retired),
        .busy(busy), .done(done), .found(found), .victim(victim), .migrate(migrate)
    );

    // R1
    weight_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |-> (cfg_k2 > cfg_k1));

endmodule

// File: tb/test_wear_victim_sel.sv
module test_wear_victim_sel;

    localparam int NBLK = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_k1 = 8'd2;
    logic [7:0]  cfg_k2 = 8'd5;
    logic [23:0] cfg_thresh = '0;
    logic        upd_valid = 1'b0;
    logic [2:0]  upd_op = '0;
    logic [3:0]  upd_blk = '0;
    logic [10:0] upd_val = '0;
    logic        req = 1'b0;
    logic        req_region = 1'b0;
    logic        busy, done, found, migrate;
    logic [3:0]  victim;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wear_victim_sel i_wear_victim_sel (
        .clk(clk), .rst_n(rst_n), .cfg_k1(cfg_k1), .cfg_k2(cfg_k2),
        .cfg_thresh(cfg_thresh), .upd_valid(upd_valid), .upd_op(upd_op),
        .upd_blk(upd_blk), .upd_val(upd_val), .req(req), .req_region(req_region),
        .busy(busy), .done(done), .found(found), .victim(victim), .migrate(migrate)
    );

    typedef struct packed {
        logic        is_req;
        logic [2:0]  op;
        logic [3:0]  blk;
        logic [10:0] val;
        logic        rg;
        logic [23:0] thr;
        logic        ef;
        logic [3:0]  ev;
        logic        em;
    } vec_t;

    // k1 = 2, k2 = 5 throughout.
    localparam vec_t VEC [24] = '{
        '{1'b1, 3'd0, 4'd0,  11'd0,    1'b0, 24'd0,    1'b1, 4'd0,  1'b0}, // 0  R3 R5 ties lowest
        '{1'b1, 3'd0, 4'd0,  11'd0,    1'b1, 24'd0,    1'b1, 4'd14, 1'b0}, // 1  R4 default write region
        '{1'b0, 3'd4, 4'd0,  11'd0,    1'b0, 24'd0,    1'b0, 4'd0,  1'b0}, // 2  touch 0
        '{1'b1, 3'd0, 4'd0,  11'd0,    1'b0, 24'd0,    1'b1, 4'd1,  1'b0}, // 3  R3 touched block skipped
        '{1'b0, 3'd2, 4'd1,  11'd3,    1'b0, 24'd0,    1'b0, 4'd0,  1'b0}, // 4  ecc +3 on 1 (score 6)
        '{1'b1, 3'd0, 4'd0,  11'd0,    1'b0, 24'd6,    1'b1, 4'd1,  1'b0}, // 5  R6 gap equal to threshold
        '{1'b1, 3'd0, 4'd0,  11'd0,    1'b0, 24'd5,    1'b1, 4'd0,  1'b1}, // 6  R6 R1 gap over threshold
        '{1'b0, 3'd3, 4'd0,  11'd0,    1'b0, 24'd0,    1'b0, 4'd0,  1'b0}, // 7  slc on 0
        '{1'b0, 3'd3, 4'd0,  11'd0,    1'b0, 24'd0,    1'b0, 4'd0,  1'b0}, // 8  slc on 0 (score 10)
        '{1'b1, 3'd0, 4'd0,  11'd0,    1'b0, 24'd5,    1'b1, 4'd2,  1'b1}, // 9  R1 k2 weight moves min to 2
        '{1'b0, 3'd7, 4'd1,  11'd0,    1'b0, 24'd0,    1'b0, 4'd0,  1'b0}, // 10 retire 1
        '{1'b1, 3'd0, 4'd0,  11'd0,    1'b0, 24'd0,    1'b1, 4'd2,  1'b0}, // 11 R7 retired skipped
        '{1'b0, 3'd1, 4'd15, 11'd0,    1'b0, 24'd0,    1'b0, 4'd0,  1'b0}, // 12 erase 15
        '{1'b0, 3'd1, 4'd15, 11'd0,    1'b0, 24'd0,    1'b0, 4'd0,  1'b0}, // 13 erase 15 (score 2)
        '{1'b0, 3'd4, 4'd14, 11'd0,    1'b0, 24'd0,    1'b0, 4'd0,  1'b0}, // 14 touch 14
        '{1'b1, 3'd0, 4'd0,  11'd0,    1'b1, 24'd1,    1'b1, 4'd2,  1'b1}, // 15 R2 R5 min from other region
        '{1'b1, 3'd0, 4'd0,  11'd0,    1'b1, 24'd2,    1'b1, 4'd15, 1'b0}, // 16 R2 R6 two erases
        '{1'b0, 3'd6, 4'd2,  11'd0,    1'b0, 24'd0,    1'b0, 4'd0,  1'b0}, // 17 move 2 to write
        '{1'b1, 3'd0, 4'd0,  11'd0,    1'b0, 24'd0,    1'b1, 4'd3,  1'b0}, // 18 R4 moved block left read
        '{1'b0, 3'd2, 4'd4,  11'd1000, 1'b0, 24'd0,    1'b0, 4'd0,  1'b0}, // 19 ecc +1000 on 4
        '{1'b0, 3'd2, 4'd4,  11'd1000, 1'b0, 24'd0,    1'b0, 4'd0,  1'b0}, // 20 ecc caps at 1536
        '{1'b0, 3'd4, 4'd3,  11'd0,    1'b0, 24'd0,    1'b0, 4'd0,  1'b0}, // 21 touch 3
        '{1'b1, 3'd0, 4'd0,  11'd0,    1'b0, 24'd3071, 1'b1, 4'd2,  1'b1}, // 22 R2 capped score 3072
        '{1'b1, 3'd0, 4'd0,  11'd0,    1'b0, 24'd3072, 1'b1, 4'd4,  1'b0}  // 23 R2 cap keeps gap 3072
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_upd(input logic [2:0] op, input logic [3:0] blk, input logic [10:0] val);
        upd_valid = 1'b1; upd_op = op; upd_blk = blk; upd_val = val;
        @(negedge clk);
        upd_valid = 1'b0; upd_op = '0;
    endtask

    logic r_found, r_mig, r_pulse;
    logic [3:0] r_vic;

    task automatic run_req(input logic rg, input logic [23:0] thr, output int lat);
        req_region = rg; cfg_thresh = thr; req = 1'b1;
        @(negedge clk);
        req = 1'b0; lat = 1;
        while (!done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        r_found = found; r_vic = victim; r_mig = migrate;
        @(negedge clk);
        r_pulse = !done;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired R8 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        int extra;
        @(negedge clk);
        do_reset();
        // R9 reset state
        check("R9 busy after reset", busy, 0);
        check("R9 done after reset", done, 0);

        for (int i = 0; i < 24; i++) begin
            if (VEC[i].is_req) begin
                run_req(VEC[i].rg, VEC[i].thr, lat);
                check($sformatf("vec %0d found (R3 R7)", i), r_found, VEC[i].ef);
                check($sformatf("vec %0d victim (R3 R5 R6)", i), r_vic, VEC[i].ev);
                check($sformatf("vec %0d migrate (R6)", i), r_mig, VEC[i].em);
            end else begin
                do_upd(VEC[i].op, VEC[i].blk, VEC[i].val);
            end
        end

        // R8 latency and single-cycle done
        run_req(1'b0, 24'd0, lat);
        check("R8 latency", lat, NBLK + 1);
        check("R8 done one cycle", r_pulse, 1);

        // R8 request during busy is dropped; write region LRU is 2, read would be 4
        req_region = 1'b1; cfg_thresh = 24'hFFFFFF; req = 1'b1;
        @(negedge clk);
        req = 1'b0; lat = 1;
        repeat (3) begin @(negedge clk); lat++; end
        req_region = 1'b0; cfg_thresh = 24'd0; req = 1'b1;
        @(negedge clk);
        req = 1'b0; lat++;
        check("R8 busy during search", busy, 1);
        while (!done && lat < 64) begin @(negedge clk); lat++; end
        check("R8 latency unchanged by second req", lat, NBLK + 1);
        check("R8 first request served victim", victim, 2);
        check("R8 first request migrate", migrate, 0);
        extra = 0;
        repeat (24) begin @(negedge clk); if (done) extra++; end
        check("R8 dropped request leaves no done", extra, 0);

        // R7 region with no live block
        do_upd(3'd7, 4'd14, 11'd0);
        do_upd(3'd7, 4'd15, 11'd0);
        do_upd(3'd7, 4'd2, 11'd0);
        run_req(1'b1, 24'd0, lat);
        check("R7 empty region found", r_found, 0);
        check("R7 empty region migrate", r_mig, 0);

        // R9 reset clears record; R4 default split restored
        do_reset();
        check("R9 busy after second reset", busy, 0);
        run_req(1'b0, 24'd0, lat);
        check("R9 read victim after reset", r_vic, 0);
        check("R9 read migrate after reset", r_mig, 0);
        run_req(1'b1, 24'd0, lat);
        check("R4 write victim after reset", r_vic, 14);
        check("R4 write found after reset", r_found, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule